// File: doc/BRIEF.md
# Staggered PWM Port Controller

The block drives five LED current-sink ports and one boost-converter enable. All six channels share one step counter of 256 steps. A single-cycle `step_tick` input advances the counter, so the surrounding logic sets the real step time. The nominal period is 8.192 ms, which gives a 32 µs step. Each port has one 8-bit register, and that one value holds both the port's mode and its PWM intensity. The value picks one of four modes. `MODE_OUT` is a static low-driving output. `MODE_IN` is a logic input. `MODE_HIZ` is high impedance. `MODE_PWM` is a constant-current sink whose on-time in steps equals the register value.

By default the channels are staggered: each channel opens its PWM window at its own fixed start step, so the sink currents do not all switch together. One control bit puts every channel in phase at step 0 instead. Every channel holds an active copy of its register. That copy reloads only when the channel's own period begins, so a write never cuts a pulse short or stretches it.

Each channel has a two-state machine with the states `CH_DARK` and `CH_LIT`. It moves only on a tick. The `LIGHT` transition (`CH_DARK` to `CH_LIT`) happens when the next phase lies inside the on-window. The `DOUSE` transition (`CH_LIT` to `CH_DARK`) happens when the next phase leaves the window, or when a reload brings a non-PWM value. A simple register port gives write and read access to the registers. It includes a read-only input-status register. A standby flag shows when no port is sinking PWM current.

Top module: `stagger_pwm_ctrl`

## Requirements
- R1: The 8-bit step counter advances by exactly one on each clock edge where `step_tick` is high. It wraps from 255 to 0 and holds its value when `step_tick` is low.
- R2: Port value decode:
  - 0x00 selects static output: `drive_low` is 1 and `sink_en` is 0.
  - 0x01 selects input: both `drive_low` and `sink_en` are 0.
  - 0xFF selects high impedance: both are 0.
  - 0x02 to 0xFE selects PWM.
- R3: A PWM port's `sink_en` is 1 exactly while (step − offset) mod 256 is less than its active value. The window wraps across the counter boundary.
- R4: When control bit 0 is 0, the start offsets are:
  - port 0: step 0
  - port 2: step 42
  - port 3: step 84
  - port 1: step 126
  - port 4: step 168
  - boost: step 210
- R5: When control bit 0 is 1, every offset is 0. A change of the control bit takes effect on the tick that wraps the counter from 255 to 0.
- R6: `boost_en` is 1 exactly while the boost channel's phase is less than the boost register value. A value of 0 keeps it off.
- R7: A written value becomes active on the tick that brings that channel's phase to 0. Until that tick the previous value governs the outputs.
- R8: Address 7 reads `pad_in[i]` in bit i (i = 0..4) for ports whose active mode is input. It reads 0 in every other bit, and bits 7:5 always read 0.
- R9: Writes to address 7 are ignored. All readable registers and all outputs behave as if no write took place.
- R10: `standby` is 1 exactly when every port's active value is 0x00, 0x01 or 0xFF.
- R11: The register map, with combinational reads:
  - addresses 0 to 4: port registers, reset value 0xFF
  - address 5: boost duty, reset value 0x00
  - address 6: control; bit 0 selects in-phase and bits 7:1 read 0
- R12: After reset:
  - the counter is at 0
  - all ports are high impedance
  - the boost channel is off
  - `standby` is 1

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_tick | input | 1 | One-cycle pulse that advances the step counter |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 3 | Write address |
| cfg_wr_data | input | 8 | Write data |
| cfg_rd_addr | input | 3 | Read address |
| cfg_rd_data | output | 8 | Read data (combinational) |
| pad_in | input | 5 | Logic levels sampled at the five ports |
| sink_en | output | 5 | Current-sink enable per port |
| drive_low | output | 5 | Static output drive per port |
| boost_en | output | 1 | Boost-converter enable |
| standby | output | 1 | No port configured for PWM |

## Verification
The assertions assume that `pad_in`, `step_tick` and the register-port inputs are synchronous to `clk` and change only between clock edges. They also assume that the read and write addresses never exceed 7. The bench meets these assumptions by driving every input on the falling edge and drawing addresses from the 3-bit range only. It drives `pad_in` from a random word on each cycle, still on the falling edge. Tick patterns include a tick on every cycle and a tick on every third cycle, so that the counter-hold behaviour is exercised alongside rapid period turnover.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    localparam int NUM_PORTS = 5;
    localparam int NUM_CH    = NUM_PORTS + 1;
    localparam int STEP_W    = 8;
    localparam int REG_W     = 8;
    localparam int ADDR_W    = 3;

    typedef enum logic [1:0] {
        MODE_OUT,
        MODE_IN,
        MODE_HIZ,
        MODE_PWM
    } port_mode_e;

    // Mode and intensity share one register value.
    function automatic port_mode_e decode_mode(input logic [REG_W-1:0] v);
        if (v == '0)
            return MODE_OUT;
        else if (v == REG_W'(1))
            return MODE_IN;
        else if (v == '1)
            return MODE_HIZ;
        else
            return MODE_PWM;
    endfunction

    // Position of each channel in the staggered start order.
    // Channel index NUM_PORTS is the boost channel.
    function automatic int unsigned stagger_rank(input int unsigned ch);
        case (ch)
            0:       return 0;
            1:       return 3;
            2:       return 1;
            3:       return 2;
            4:       return 4;
            default: return 5;
        endcase
    endfunction

endpackage

// File: rtl/spwm_timebase.sv
module spwm_timebase #(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_tick,
    output logic [STEP_W-1:0] step_nx,
    output logic              wrap_nx
);

    logic [STEP_W-1:0] step_q;

    // Value the counter takes at the coming edge.
    assign step_nx = step_tick ? step_q + STEP_W'(1) : step_q;
    assign wrap_nx = step_tick && (step_q == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            step_q <= '0;
        else
            step_q <= step_nx;
    end

    // R1: the counter holds without a tick
    a_r1_hold_without_tick: assert property (
        @(posedge clk) disable iff (!rst_n)
        !step_tick |=> $stable(step_q)
    );

    // R1: the counter steps by one per tick, modulo 2**STEP_W
    a_r1_step_by_one: assert property (
        @(posedge clk) disable iff (!rst_n)
        step_tick |=> (step_q == STEP_W'($past(step_q) + STEP_W'(1)))
    );

endmodule

// File: rtl/spwm_regbank.sv
module spwm_regbank #(
    parameter int REG_W     = 8,
    parameter int NUM_PORTS = 5,
    parameter int ADDR_W    = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [REG_W-1:0]                wr_data,
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [NUM_PORTS-1:0]            status_in,
    output logic [REG_W-1:0]                rd_data,
    output logic [NUM_PORTS-1:0][REG_W-1:0] port_sh,
    output logic [REG_W-1:0]                boost_sh,
    output logic                            inphase_sh
);

    localparam logic [ADDR_W-1:0] ADDR_BOOST  = ADDR_W'(NUM_PORTS);
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = ADDR_W'(NUM_PORTS + 1);
    localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(NUM_PORTS + 2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++)
                port_sh[p] <= '1;
            boost_sh   <= '0;
            inphase_sh <= 1'b0;
        end else if (wr_en) begin
            for (int p = 0; p < NUM_PORTS; p++)
                if (wr_addr == ADDR_W'(p))
                    port_sh[p] <= wr_data;
            if (wr_addr == ADDR_BOOST)
                boost_sh <= wr_data;
            if (wr_addr == ADDR_CTRL)
                inphase_sh <= wr_data[0];
            // a write to ADDR_STATUS stores nothing
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_BOOST)
            rd_data = port_sh[rd_addr];
        else if (rd_addr == ADDR_BOOST)
            rd_data = boost_sh;
        else if (rd_addr == ADDR_CTRL)
            rd_data = {{(REG_W-1){1'b0}}, inphase_sh};
        else if (rd_addr == ADDR_STATUS)
            rd_data = {{(REG_W-NUM_PORTS){1'b0}}, status_in};
    end

    // R9: a write to the status address leaves every stored register intact
    a_r9_status_write_ignored: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_STATUS) |=>
            ($stable(port_sh) && $stable(boost_sh) && $stable(inphase_sh))
    );

endmodule

// File: rtl/spwm_channel.sv
module spwm_channel
    import spwm_pkg::*;
#(
    parameter int               STEP_W   = 8,
    parameter int               REG_W    = 8,
    parameter int               NUM_CH   = 6,
    parameter int               CH_IDX   = 0,
    parameter bit               IS_BOOST = 1'b0,
    parameter logic [REG_W-1:0] RST_VAL  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_tick,
    input  logic [STEP_W-1:0] step_nx,
    input  logic              inphase_nx,
    input  logic [REG_W-1:0]  shadow_val,
    output logic [REG_W-1:0]  act_val,
    output logic              sink_on
);

    localparam int                STRIDE   = (1 << STEP_W) / NUM_CH;
    localparam logic [STEP_W-1:0] STAG_OFF = STEP_W'(stagger_rank(CH_IDX) * STRIDE);

    typedef enum logic {
        CH_DARK,
        CH_LIT
    } ch_state_e;

    ch_state_e         state_q, state_d;
    logic [REG_W-1:0]  act_q;
    logic [STEP_W-1:0] off_nx;
    logic [STEP_W-1:0] phase_nx;
    logic              load_nx;
    logic [REG_W-1:0]  val_nx;
    logic              pwm_nx;
    logic              lit_nx;

    // Everything below looks at the values after the coming edge.
    assign off_nx   = inphase_nx ? '0 : STAG_OFF;
    assign phase_nx = step_nx - off_nx;
    assign load_nx  = step_tick && (phase_nx == '0);
    assign val_nx   = load_nx ? shadow_val : act_q;
    assign pwm_nx   = IS_BOOST ? 1'b1 : (decode_mode(val_nx) == MODE_PWM);
    assign lit_nx   = pwm_nx && (int'(phase_nx) < int'(val_nx));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_DARK;
            act_q   <= RST_VAL;
        end else begin
            state_q <= state_d;
            if (load_nx)
                act_q <= shadow_val;
        end
    end

    // Transition process: LIGHT and DOUSE happen only on a tick.
    always_comb begin
        state_d = state_q;
        if (step_tick) begin
            unique case (state_q)
                CH_DARK: if (lit_nx)  state_d = CH_LIT;   // LIGHT
                CH_LIT:  if (!lit_nx) state_d = CH_DARK;  // DOUSE
                default: state_d = CH_DARK;
            endcase
        end
    end

    // Output process
    always_comb begin
        sink_on = (state_q == CH_LIT);
        act_val = act_q;
    end

    // R7: the active value changes only on a tick edge
    a_r7_reload_on_tick: assert property (
        @(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> $past(step_tick)
    );

    // R3: a lit channel always holds a PWM-class value
    a_r3_lit_only_pwm: assert property (
        @(posedge clk) disable iff (!rst_n)
        sink_on |-> (IS_BOOST || decode_mode(act_q) == MODE_PWM)
    );

    // R3: the window never extends beyond the value
    a_r3_zero_never_lit: assert property (
        @(posedge clk) disable iff (!rst_n)
        (act_q == '0) |-> !sink_on
    );

endmodule

// File: rtl/stagger_pwm_ctrl.sv
module stagger_pwm_ctrl
    import spwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_tick,
    input  logic        cfg_wr_en,
    input  logic [2:0]  cfg_wr_addr,
    input  logic [7:0]  cfg_wr_data,
    input  logic [2:0]  cfg_rd_addr,
    output logic [7:0]  cfg_rd_data,
    input  logic [4:0]  pad_in,
    output logic [4:0]  sink_en,
    output logic [4:0]  drive_low,
    output logic        boost_en,
    output logic        standby
);

    localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(NUM_PORTS + 2);

    logic [STEP_W-1:0]               step_nx;
    logic                            wrap_nx;
    logic [NUM_PORTS-1:0][REG_W-1:0] port_sh;
    logic [REG_W-1:0]                boost_sh;
    logic                            inphase_sh;
    logic                            inphase_q;
    logic                            inphase_nx;
    logic [REG_W-1:0]                port_act [NUM_PORTS];
    logic [REG_W-1:0]                boost_act;
    port_mode_e                      port_mode [NUM_PORTS];
    logic [NUM_PORTS-1:0]            port_lit;
    logic [NUM_PORTS-1:0]            input_mask;
    logic [NUM_PORTS-1:0]            status_w;
    logic                            boost_lit;

    spwm_timebase #(
        .STEP_W    (STEP_W)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_tick (step_tick),
        .step_nx   (step_nx),
        .wrap_nx   (wrap_nx)
    );

    spwm_regbank #(
        .REG_W      (REG_W),
        .NUM_PORTS  (NUM_PORTS),
        .ADDR_W     (ADDR_W)
    ) u_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_addr    (cfg_wr_addr),
        .wr_data    (cfg_wr_data),
        .rd_addr    (cfg_rd_addr),
        .status_in  (status_w),
        .rd_data    (cfg_rd_data),
        .port_sh    (port_sh),
        .boost_sh   (boost_sh),
        .inphase_sh (inphase_sh)
    );

    // The phase-alignment choice changes only on a counter wrap.
    assign inphase_nx = wrap_nx ? inphase_sh : inphase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            inphase_q <= 1'b0;
        else
            inphase_q <= inphase_nx;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        spwm_channel #(
            .STEP_W     (STEP_W),
            .REG_W      (REG_W),
            .NUM_CH     (NUM_CH),
            .CH_IDX     (p),
            .IS_BOOST   (1'b0),
            .RST_VAL    ('1)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .step_tick  (step_tick),
            .step_nx    (step_nx),
            .inphase_nx (inphase_nx),
            .shadow_val (port_sh[p]),
            .act_val    (port_act[p]),
            .sink_on    (port_lit[p])
        );
        assign port_mode[p] = decode_mode(port_act[p]);
    end

    spwm_channel #(
        .STEP_W     (STEP_W),
        .REG_W      (REG_W),
        .NUM_CH     (NUM_CH),
        .CH_IDX     (NUM_PORTS),
        .IS_BOOST   (1'b1),
        .RST_VAL    ('0)
    ) u_boost (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_tick  (step_tick),
        .step_nx    (step_nx),
        .inphase_nx (inphase_nx),
        .shadow_val (boost_sh),
        .act_val    (boost_act),
        .sink_on    (boost_lit)
    );

    // Output process
    always_comb begin
        standby = 1'b1;
        for (int p = 0; p < NUM_PORTS; p++) begin
            unique case (port_mode[p])
                MODE_OUT: begin
                    sink_en[p]    = 1'b0;
                    drive_low[p]  = 1'b1;
                    input_mask[p] = 1'b0;
                end
                MODE_IN: begin
                    sink_en[p]    = 1'b0;
                    drive_low[p]  = 1'b0;
                    input_mask[p] = 1'b1;
                end
                MODE_HIZ: begin
                    sink_en[p]    = 1'b0;
                    drive_low[p]  = 1'b0;
                    input_mask[p] = 1'b0;
                end
                MODE_PWM: begin
                    sink_en[p]    = port_lit[p];
                    drive_low[p]  = 1'b0;
                    input_mask[p] = 1'b0;
                    standby       = 1'b0;
                end
                default: begin
                    sink_en[p]    = 1'b0;
                    drive_low[p]  = 1'b0;
                    input_mask[p] = 1'b0;
                end
            endcase
        end
        status_w = pad_in & input_mask;
        boost_en = boost_lit;
    end

    // R10: standby implies no sink is active
    a_r10_standby_no_sink: assert property (
        @(posedge clk) disable iff (!rst_n)
        standby |-> (sink_en == '0)
    );

    // R2: a port never sinks and drives at once
    a_r2_drive_sink_exclusive: assert property (
        @(posedge clk) disable iff (!rst_n)
        (sink_en & drive_low) == '0
    );

    // R8: reserved status bits read zero
    a_r8_status_upper_zero: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cfg_rd_addr == ADDR_STATUS) |-> (cfg_rd_data[REG_W-1:NUM_PORTS] == '0)
    );

    // R6: a zero boost duty keeps the boost enable off
    a_r6_boost_zero_dark: assert property (
        @(posedge clk) disable iff (!rst_n)
        (boost_act == '0) |-> !boost_en
    );

endmodule

// File: tb/stagger_pwm_ctrl_tb.sv
module stagger_pwm_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_tick = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [2:0] cfg_wr_addr = '0;
    logic [7:0] cfg_wr_data = '0;
    logic [2:0] cfg_rd_addr = '0;
    logic [7:0] cfg_rd_data;
    logic [4:0] pad_in = '0;
    logic [4:0] sink_en;
    logic [4:0] drive_low;
    logic       boost_en;
    logic       standby;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stagger_pwm_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_tick   (step_tick),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_addr (cfg_rd_addr),
        .cfg_rd_data (cfg_rd_data),
        .pad_in      (pad_in),
        .sink_en     (sink_en),
        .drive_low   (drive_low),
        .boost_en    (boost_en),
        .standby     (standby)
    );

    // Reference model state
    int m_cnt;
    int m_sh[6];
    int m_act[6];
    int m_ctrl;
    int m_inph;
    int stag[6] = '{0, 126, 42, 84, 168, 210};   // R4 offsets by channel

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        int off, ph, v;
        bit [4:0] e_sink, e_drv, e_mask;
        bit       e_boost, e_stby;
        int       e_rd;
        e_stby = 1'b1;
        for (int i = 0; i < 5; i++) begin
            v   = m_act[i];
            off = m_inph ? 0 : stag[i];
            ph  = (m_cnt - off) & 255;
            e_sink[i] = (v != 0 && v != 1 && v != 255) && (ph < v);
            e_drv[i]  = (v == 0);
            e_mask[i] = (v == 1);
            if (v != 0 && v != 1 && v != 255) e_stby = 1'b0;
        end
        off     = m_inph ? 0 : stag[5];
        e_boost = ((m_cnt - off) & 255) < m_act[5];
        case (cfg_rd_addr)
            3'd6:    e_rd = m_ctrl;
            3'd7:    e_rd = int'(pad_in & e_mask);
            default: e_rd = m_sh[cfg_rd_addr];
        endcase
        check(sink_en == e_sink, "R3/R4/R5/R7 sink_en", sink_en, e_sink);
        check(drive_low == e_drv, "R2 drive_low", drive_low, e_drv);
        check(boost_en == e_boost, "R6/R1 boost_en", boost_en, e_boost);
        check(standby == e_stby, "R10 standby", standby, e_stby);
        check(int'(cfg_rd_data) == e_rd, "R11/R8/R9 cfg_rd_data", cfg_rd_data, e_rd);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ctrl = 0; m_inph = 0;
            for (int i = 0; i < 6; i++) begin
                m_sh[i]  = (i < 5) ? 255 : 0;
                m_act[i] = m_sh[i];
            end
        end else begin
            int inph_new, off;
            inph_new = (step_tick && m_cnt == 255) ? m_ctrl : m_inph;
            if (step_tick)
                for (int i = 0; i < 6; i++) begin
                    off = inph_new ? 0 : stag[i];
                    if (((m_cnt + 1 - off) & 255) == 0) m_act[i] = m_sh[i];
                end
            m_inph = inph_new;
            if (step_tick) m_cnt = (m_cnt + 1) & 255;
            if (cfg_wr_en) begin
                if (cfg_wr_addr <= 3'd5) m_sh[cfg_wr_addr] = int'(cfg_wr_data);
                else if (cfg_wr_addr == 3'd6) m_ctrl = int'(cfg_wr_data[0]);
            end
        end
        #2;
        if (rst_n && !done) compare();
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = 3'(a);
        cfg_wr_data = 8'(d);
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic run(input int cycles, input int tick_every);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            step_tick   = (c % tick_every) == 0;
            cfg_rd_addr = 3'(c);
            pad_in      = 5'($urandom);
        end
        @(negedge clk);
        step_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(standby == 1'b1, "R12 standby", standby, 1);
        check(sink_en == 5'd0 && boost_en == 1'b0, "R12 outputs", {boost_en, sink_en}, 0);
        check(cfg_rd_data == 8'hFF, "R12 port0 reset", cfg_rd_data, 8'hFF);

        // R2/R3/R4: mixed modes, staggered
        wr(0, 8'h80); wr(1, 8'h02); wr(2, 8'h00); wr(3, 8'h01); wr(4, 8'hFE); wr(5, 8'h40);
        run(600, 1);
        // R7: mid-period rewrite
        wr(0, 8'h10); run(100, 1); wr(4, 8'h30); run(400, 1);
        // R9: writes to the status address are ignored
        wr(7, 8'h5A); run(300, 1);
        // R5: all channels in phase
        wr(6, 8'hFF); run(600, 1);
        // R10/R1: standby mix and sparse ticks
        wr(0, 8'hFF); wr(1, 8'h01); wr(4, 8'h00); wr(5, 8'hFF);
        run(900, 3);
        wr(3, 8'hC0); run(300, 3);
        // R5: back to staggered, boost off
        wr(6, 8'h00); wr(5, 8'h00); wr(1, 8'h99); run(700, 1);
        wr(5, 8'h01); run(400, 1);

        done = 1'b1;
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule